// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write qualifier of a parallel NOR-style flash control interface. Each cycle it may receive one qualified bus write, made up of an address, a data byte and a strobe. From a run of such writes it recognises multi-write command sequences. Every sequence opens with two fixed unlock writes. From the sequence it decides what a read of the array returns: the stored array contents, identification values, or operation status.

When a program or erase sequence completes, the decoder emits a one-cycle start pulse carrying the target address, and for a program, the data byte. An external embedded-algorithm stub runs the operation and reports back through a busy level and a failure level. While the operation runs, the decoder ignores every write and steers reads to status. A failure report keeps reads on status until a reset command is written. Identification values come from module parameters: the manufacturer code, the device code and one protect bit per sector.

The read-select encoding is 0 for array, 1 for identification and 2 for status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_sel is 0 (array read) and neither prog_start nor erase_start is asserted. Array reads need no command.
- R2: Every command is opened by two unlock writes, AAh at address 555h and then 55h at address 2AAh, compared on the low 11 address bits. The command write follows, at 555h: 90h for identification, A0h for program, 80h for erase.
- R3: A write whose address or data does not match the next expected step, or that arrives out of order, sends the sequence back to the start. rd_sel stays 0, and no start pulse is produced by the writes that follow unless a fresh unlock prelude begins.
- R4: A write of F0h at any address is the reset command. When accepted, it abandons any partial sequence, leaves identification mode, clears the failure flag, and returns rd_sel to 0.
- R5: The sequence AAh/555h, 55h/2AAh, 90h/555h sets rd_sel to 1. The mode holds across any number of reads and any non-F0h writes, and only the reset command ends it.
- R6: In identification mode, id_data depends on rd_addr. Low byte 00h gives MFR_CODE. Low byte 01h gives DEV_CODE. Low byte 02h gives 01h if the sector selected by the top log2(NUM_SECT) address bits is set in PROT_MASK, and 00h if it is not. Any other low byte gives 00h.
- R7: A program sequence is four writes: the two unlock writes, A0h at 555h, then the target address and byte. prog_start is high for exactly one cycle, the cycle after the fourth write, with op_addr and op_data equal to that write's address and data.
- R8: An erase sequence is AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, then a final write. 30h at any address starts a sector erase: erase_start pulses with erase_all 0 and op_addr equal to that address. 10h at 555h starts a whole-array erase: erase_all is 1. Any other final write aborts the sequence.
- R9: From a start pulse until busy_in has been seen high and then low, and at any time busy_in is high, rd_sel is 2. Every write is ignored during this window, including F0h.
- R10: A high fail_in sets a sticky failure flag that holds rd_sel at 2. While the flag is set, writes other than F0h are ignored. Only an accepted reset command clears the flag.
- R11: A reset command written in place of the program target write, or between any two writes of a sequence, produces no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Qualified bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address, used for identification values |
| busy_in | input | 1 | Embedded operation running (from stub) |
| fail_in | input | 1 | Embedded operation failed (from stub) |
| rd_sel | output | 2 | Read source: 0 array, 1 identification, 2 status |
| id_data | output | 8 | Identification value for rd_addr |
| prog_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_all | output | 1 | Erase targets whole array (valid with erase_start) |
| op_addr | output | ADDR_W | Target address of the started operation |
| op_data | output | 8 | Byte to program |

## Verification
The bench builds the decoder with a 16-bit address, four sectors, codes C2h and 3Dh, and protect mask 0101b. With only four sectors, every sector index can be read in identification mode. The alternating mask makes an off-by-one in the sector slice show up as a wrong protect byte on neighbouring sectors. The shorter address still leaves the upper bits above the 11-bit unlock field, so a sector-erase target address is distinguishable from the unlock addresses.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int KEY_W = 11;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_ID     = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ER1,
    SQ_ER2,
    SQ_ER3
  } seq_e;

  localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]       KEY_DATA_A = 8'hAA;
  localparam logic [7:0]       KEY_DATA_B = 8'h55;
  localparam logic [7:0]       CMD_ID     = 8'h90;
  localparam logic [7:0]       CMD_PGM    = 8'hA0;
  localparam logic [7:0]       CMD_ERASE  = 8'h80;
  localparam logic [7:0]       CMD_RESET  = 8'hF0;
  localparam logic [7:0]       CMD_SECT   = 8'h30;
  localparam logic [7:0]       CMD_CHIP   = 8'h10;

  function automatic logic is_key_a(input logic [KEY_W-1:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_A) && (d == KEY_DATA_A);
  endfunction

  function automatic logic is_key_b(input logic [KEY_W-1:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_B) && (d == KEY_DATA_B);
  endfunction

  function automatic rd_sel_e pick_read(input logic status, input logic ident);
    if (status)     return RD_STATUS;
    else if (ident) return RD_ID;
    else            return RD_ARRAY;
  endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [KEY_W-1:0] key_addr,
  input  logic [7:0]       wr_data,
  input  logic             hold,
  output logic             ev_reset,
  output logic             ev_id,
  output logic             ev_prog,
  output logic             ev_erase,
  output logic             ev_chip,
  output logic             ev_bad
);

  seq_e state, nxt;

  always_comb begin
    nxt      = state;
    ev_reset = 1'b0;
    ev_id    = 1'b0;
    ev_prog  = 1'b0;
    ev_erase = 1'b0;
    ev_chip  = 1'b0;
    ev_bad   = 1'b0;
    if (wr_ok) begin
      if (wr_data == CMD_RESET) begin
        ev_reset = 1'b1;
        nxt      = SQ_IDLE;
      end else if (!hold) begin
        unique case (state)
          SQ_IDLE: if (is_key_a(key_addr, wr_data)) nxt = SQ_UNL1; else ev_bad = 1'b1;
          SQ_UNL1: if (is_key_b(key_addr, wr_data)) nxt = SQ_UNL2; else ev_bad = 1'b1;
          SQ_UNL2: begin
            if (key_addr != KEY_ADDR_A)   ev_bad = 1'b1;
            else if (wr_data == CMD_ID)   begin ev_id = 1'b1; nxt = SQ_IDLE; end
            else if (wr_data == CMD_PGM)  nxt = SQ_PGM;
            else if (wr_data == CMD_ERASE) nxt = SQ_ER1;
            else                          ev_bad = 1'b1;
          end
          SQ_PGM: begin
            ev_prog = 1'b1;
            nxt     = SQ_IDLE;
          end
          SQ_ER1: if (is_key_a(key_addr, wr_data)) nxt = SQ_ER2; else ev_bad = 1'b1;
          SQ_ER2: if (is_key_b(key_addr, wr_data)) nxt = SQ_ER3; else ev_bad = 1'b1;
          SQ_ER3: begin
            if (wr_data == CMD_SECT) begin
              ev_erase = 1'b1;
              nxt      = SQ_IDLE;
            end else if (wr_data == CMD_CHIP && key_addr == KEY_ADDR_A) begin
              ev_erase = 1'b1;
              ev_chip  = 1'b1;
              nxt      = SQ_IDLE;
            end else begin
              ev_bad = 1'b1;
            end
          end
          default: ev_bad = 1'b1;
        endcase
        if (ev_bad) nxt = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  AST_BAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> state == SQ_IDLE); // R3

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && wr_ok && wr_data != CMD_RESET) |=> state == $past(state)); // R5

  AST_RESET_CLEARS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> state == SQ_IDLE); // R11

endmodule

// File: rtl/fcd_mode_ctl.sv
module fcd_mode_ctl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_reset,
  input  logic              ev_id,
  input  logic              ev_prog,
  input  logic              ev_erase,
  input  logic              ev_chip,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy_in,
  input  logic              fail_in,
  output logic              op_busy,
  output logic              hold,
  output logic [1:0]        rd_sel,
  output logic              prog_start,
  output logic              erase_start,
  output logic              erase_all,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  logic id_mode, fail_flag, run, seen_busy;
  logic op_launch;

  assign op_launch = ev_prog | ev_erase;
  assign op_busy   = run | busy_in;
  assign hold      = id_mode | fail_flag;
  assign rd_sel    = pick_read(op_busy | fail_flag, id_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      seen_busy <= 1'b0;
    end else if (op_launch) begin
      run       <= 1'b1;
      seen_busy <= 1'b0;
    end else if (run) begin
      if (busy_in)        seen_busy <= 1'b1;
      else if (seen_busy) begin
        run       <= 1'b0;
        seen_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_mode   <= 1'b0;
      fail_flag <= 1'b0;
    end else begin
      if (ev_reset)   id_mode <= 1'b0;
      else if (ev_id) id_mode <= 1'b1;
      if (fail_in)       fail_flag <= 1'b1;
      else if (ev_reset) fail_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      erase_all   <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      prog_start  <= ev_prog;
      erase_start <= ev_erase;
      if (op_launch) op_addr   <= wr_addr;
      if (ev_prog)   op_data   <= wr_data;
      if (ev_erase)  erase_all <= ev_chip;
    end
  end

  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start); // R7

  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R8

  AST_ID_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !ev_reset) |=> id_mode); // R5

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> !(prog_start || erase_start)); // R9

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !ev_reset) |=> fail_flag); // R10

  AST_ONE_START_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start)); // R7

endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
  parameter int                  ADDR_W    = 19,
  parameter int                  NUM_SECT  = 8,
  parameter logic [7:0]          MFR_CODE  = 8'h01,
  parameter logic [7:0]          DEV_CODE  = 8'h51,
  parameter logic [NUM_SECT-1:0] PROT_MASK = '0
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_data
);

  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic [SECT_W-1:0]   sect_idx;
  logic [NUM_SECT-1:0] prot_hit;
  logic                sect_prot;

  assign sect_idx = rd_addr[ADDR_W-1 -: SECT_W];

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    assign prot_hit[g] = (sect_idx == SECT_W'(g)) && PROT_MASK[g];
  end

  assign sect_prot = |prot_hit;

  always_comb begin
    unique case (rd_addr[7:0])
      8'h00:   id_data = MFR_CODE;
      8'h01:   id_data = DEV_CODE;
      8'h02:   id_data = {7'd0, sect_prot};
      default: id_data = 8'h00;
    endcase
  end

  always_comb begin
    AST_PROT_ONEHOT: assert ($onehot0(prot_hit)); // R6
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int                  ADDR_W    = 19,
  parameter int                  NUM_SECT  = 8,
  parameter logic [7:0]          MFR_CODE  = 8'h01,
  parameter logic [7:0]          DEV_CODE  = 8'h51,
  parameter logic [NUM_SECT-1:0] PROT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy_in,
  input  logic              fail_in,
  output logic [1:0]        rd_sel,
  output logic [7:0]        id_data,
  output logic              prog_start,
  output logic              erase_start,
  output logic              erase_all,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  logic wr_ok, op_busy, hold;
  logic ev_reset, ev_id, ev_prog, ev_erase, ev_chip, ev_bad;

  assign wr_ok = wr_en & ~op_busy;

  fcd_seq_fsm u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .key_addr (wr_addr[KEY_W-1:0]),
    .wr_data  (wr_data),
    .hold     (hold),
    .ev_reset (ev_reset),
    .ev_id    (ev_id),
    .ev_prog  (ev_prog),
    .ev_erase (ev_erase),
    .ev_chip  (ev_chip),
    .ev_bad   (ev_bad)
  );

  fcd_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_reset    (ev_reset),
    .ev_id       (ev_id),
    .ev_prog     (ev_prog),
    .ev_erase    (ev_erase),
    .ev_chip     (ev_chip),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy_in     (busy_in),
    .fail_in     (fail_in),
    .op_busy     (op_busy),
    .hold        (hold),
    .rd_sel      (rd_sel),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .erase_all   (erase_all),
    .op_addr     (op_addr),
    .op_data     (op_data)
  );

  fcd_id_rom #(
    .ADDR_W    (ADDR_W),
    .NUM_SECT  (NUM_SECT),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE),
    .PROT_MASK (PROT_MASK)
  ) u_id (
    .rd_addr (rd_addr),
    .id_data (id_data)
  );

  AST_RESET_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reset && !fail_in) |=> (rd_sel == RD_ARRAY || busy_in)); // R4

  AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> !(prog_start || erase_start)); // R3

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy_in = 1'b0;
  logic          fail_in = 1'b0;
  logic [1:0]    rd_sel;
  logic [7:0]    id_data;
  logic          prog_start, erase_start, erase_all;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .NUM_SECT(4), .MFR_CODE(8'hC2), .DEV_CODE(8'h3D), .PROT_MASK(4'b0101)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy_in(busy_in), .fail_in(fail_in), .rd_sel(rd_sel),
    .id_data(id_data), .prog_start(prog_start), .erase_start(erase_start),
    .erase_all(erase_all), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one write; returns at the falling edge after the sampling edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic finish_op();
    @(negedge clk); busy_in = 1'b1;
    repeat (3) @(negedge clk);
    busy_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "rd_sel after reset", rd_sel, 0);
    check("R1", "prog_start after reset", prog_start, 0);
    check("R1", "erase_start after reset", erase_start, 0);
  endtask

  task automatic t_autoselect();
    unlock();
    wr(16'h0555, 8'h90);
    check("R2", "rd_sel after id command", rd_sel, 1);
    rd_addr = 16'h0000; #1 check("R6", "manufacturer", id_data, 8'hC2);
    rd_addr = 16'h3001; #1 check("R6", "device", id_data, 8'h3D);
    rd_addr = 16'h0002; #1 check("R6", "sector0 protect", id_data, 8'h01);
    rd_addr = 16'h4002; #1 check("R6", "sector1 protect", id_data, 8'h00);
    rd_addr = 16'h8002; #1 check("R6", "sector2 protect", id_data, 8'h01);
    rd_addr = 16'hC002; #1 check("R6", "sector3 protect", id_data, 8'h00);
    rd_addr = 16'h0007; #1 check("R6", "other offset", id_data, 8'h00);
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h0100, 8'h33);
    check("R5", "no program from id mode", prog_start, 0);
    check("R5", "id mode persists", rd_sel, 1);
    wr(16'h1234, 8'hF0);
    check("R4", "reset leaves id mode", rd_sel, 0);
  endtask

  task automatic t_bad_seq();
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h12);
    check("R3", "wrong unlock address, no program", prog_start, 0);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h54); wr(16'h0555, 8'h90);
    check("R3", "wrong unlock data, no id mode", rd_sel, 0);
    wr(16'h02AA, 8'h55); wr(16'h0555, 8'hAA); wr(16'h0555, 8'h90);
    check("R3", "out of order, no id mode", rd_sel, 0);
    unlock(); wr(16'h0556, 8'h90);
    check("R2", "command at wrong address ignored", rd_sel, 0);
  endtask

  task automatic t_program();
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h1234, 8'h5A);
    check("R7", "prog_start pulse", prog_start, 1);
    check("R7", "op_addr", op_addr, 16'h1234);
    check("R7", "op_data", op_data, 8'h5A);
    check("R9", "status after start", rd_sel, 2);
    @(negedge clk);
    check("R7", "pulse is one cycle", prog_start, 0);
    wr(16'h0000, 8'hF0);
    unlock(); wr(16'h0555, 8'h90);
    check("R9", "writes ignored while running", rd_sel, 2);
    @(negedge clk); busy_in = 1'b1;
    @(negedge clk);
    check("R9", "status while busy", rd_sel, 2);
    busy_in = 1'b0;
    @(negedge clk);
    check("R9", "array after busy ends, no id entry", rd_sel, 0);
  endtask

  task automatic t_reset_mid();
    wr(16'h0555, 8'hAA); wr(16'h7777, 8'hF0); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0200, 8'h11);
    check("R11", "reset between unlocks, no program", prog_start, 0);
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0300, 8'hF0);
    check("R11", "reset as program data, no program", prog_start, 0);
    check("R11", "rd_sel array after reset", rd_sel, 0);
    wr(16'h0400, 8'h22);
    check("R11", "later write does not program", prog_start, 0);
  endtask

  task automatic t_erase();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h8000, 8'h30);
    check("R8", "sector erase start", erase_start, 1);
    check("R8", "sector erase not all", erase_all, 0);
    check("R8", "sector erase address", op_addr, 16'h8000);
    finish_op();
    check("R9", "array after erase", rd_sel, 0);
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0555, 8'h10);
    check("R8", "chip erase start", erase_start, 1);
    check("R8", "chip erase all", erase_all, 1);
    finish_op();
    unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0123, 8'h10);
    check("R8", "chip erase at wrong address aborts", erase_start, 0);
  endtask

  task automatic t_fail();
    @(negedge clk); fail_in = 1'b1;
    @(negedge clk); fail_in = 1'b0;
    check("R10", "status on fail", rd_sel, 2);
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0500, 8'h44);
    check("R10", "program ignored while failed", prog_start, 0);
    check("R10", "fail sticky", rd_sel, 2);
    wr(16'h0ABC, 8'hF0);
    check("R10", "reset clears fail", rd_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_autoselect();
    t_bad_seq();
    t_program();
    t_reset_mid();
    t_erase();
    t_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule